// File: doc/BRIEF.md
# Core Low-Power Mode Sequencer

This block steers a processor core between full power and two low-power states, nap and sleep. Software arms a power-down in three steps: it enables power management, marks the core as allowed to switch off, and then raises a nap or sleep request bit. The sequencer accepts only that order. It then waits for the snoop bus to go quiet, stops snooping, gates the core clock and, if configured, puts the DRAM into self-refresh through a request/acknowledge handshake. While the DRAM is in self-refresh, it blocks the other bus masters from reaching it.

Each low-power mode has its own set of wake events. On a wake, the sequencer either counts a short fixed restart delay or first takes the DRAM out of self-refresh. It then returns to full power. When another bus master becomes active during a low-power mode and its enable is set, that activity wakes the core and raises a one-cycle wake interrupt.

Top module: `lpm_sequencer`

## Requirements
- R1: A request is accepted only if power-enable was set first, then core-off rose while power-enable was already high in the previous cycle, and both are still high when the request rises. Otherwise, a request raised at full power is ignored and `seq_err_o` goes high and stays high until reset.
- R2: A request is a 0-to-1 change of `nap_bit_i` (core config bit 9) or `sleep_bit_i` (core config bit 10). If both rise together, sleep wins. `lp_mode_o` reads 2'b01 for nap, 2'b10 for sleep and 2'b00 at full power, from acceptance until the return to full power.
- R3: After acceptance, entry waits for `snoop_idle_i`. `snoop_dis_o` is high from entry until the return to full power. `core_gate_o` is high for the whole time the core is in low power.
- R4: A core wake event that arrives while entry still waits for snoop idle cancels the entry. The next cycle is full power, and snooping is never disabled.
- R5: With `dram_off_i` high at entry, `sr_req_o` and `alt_block_o` rise. The low-power state is held until `sr_ack_i` is high.
- R6: With `dram_off_i` low at entry, `sr_req_o` and `alt_block_o` stay low throughout.
- R7: Nap wakes on an external interrupt, a system-management interrupt, a decrementer interrupt, a reset event or a machine check.
- R8: Sleep wakes on the same events except the decrementer interrupt, which has no effect in sleep.
- R9: Without self-refresh, `snoop_dis_o` stays high for exactly WAKE_LAT cycles after the clock edge that samples the wake, then falls.
- R10: With self-refresh, a wake drops `sr_req_o`. `alt_block_o` and the low-power outputs hold until `sr_ack_i` is low, and full power follows on the next edge.
- R11: Alternate-master activity in low power wakes the core and pulses `wake_irq_o` for one cycle only when `bus_wake_en_i` is high. Otherwise it is ignored.
- R12: After reset, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| pwr_en_i | input | 1 | Power-management enable (arming step 1) |
| core_off_i | input | 1 | Core-off permission (arming step 2) |
| nap_bit_i | input | 1 | Nap request, core config bit 9 |
| sleep_bit_i | input | 1 | Sleep request, core config bit 10 |
| dram_off_i | input | 1 | Put DRAM in self-refresh during low power |
| bus_wake_en_i | input | 1 | Enable wake on alternate-master activity |
| snoop_idle_i | input | 1 | Snoop bus is idle |
| ext_irq_i | input | 1 | External interrupt |
| smi_i | input | 1 | System-management interrupt |
| dec_irq_i | input | 1 | Decrementer interrupt |
| rst_evt_i | input | 1 | Hard or soft reset event |
| mcp_i | input | 1 | Machine-check input |
| alt_act_i | input | 1 | Alternate bus master is active |
| sr_ack_i | input | 1 | DRAM self-refresh acknowledge |
| core_gate_o | output | 1 | Gate the core clock |
| snoop_dis_o | output | 1 | Disable bus snooping |
| sr_req_o | output | 1 | DRAM self-refresh request |
| alt_block_o | output | 1 | Block alternate masters from DRAM |
| wake_irq_o | output | 1 | One-cycle wake interrupt from bus activity |
| lp_mode_o | output | 2 | Current mode: 00 full, 01 nap, 10 sleep |
| seq_err_o | output | 1 | Sticky arming-order error |

## Verification
The assertions assume the DRAM controller behaves as a well-formed partner: `sr_ack_i` follows `sr_req_o` after some delay and never changes on its own. They also assume that a decrementer interrupt counts as ignored in sleep only when no other wake event is present. The bench models the DRAM controller so that it only copies the request into the acknowledge after a random delay of 0 to 3 cycles, or drives the acknowledge by hand in the same pattern. The random loop raises exactly one wake source at a time, so the expected wake outcome follows from the mode, the source and the enable alone.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

  typedef enum logic [2:0] {
    ST_FULL      = 3'd0,
    ST_WAIT_IDLE = 3'd1,
    ST_SR_ENTER  = 3'd2,
    ST_LOW       = 3'd3,
    ST_SR_EXIT   = 3'd4,
    ST_FAST_WAKE = 3'd5
  } lpm_state_e;

  typedef enum logic [1:0] {
    LPM_NONE  = 2'b00,
    LPM_NAP   = 2'b01,
    LPM_SLEEP = 2'b10
  } lpm_mode_e;

  typedef struct packed {
    logic ext_irq;
    logic smi;
    logic dec;
    logic rst_evt;
    logic mcp;
  } wake_evt_t;

  // Sleep outranks nap when both rise together.
  function automatic lpm_mode_e pick_mode(input logic nap_rise, input logic sleep_rise);
    if (sleep_rise)    return LPM_SLEEP;
    else if (nap_rise) return LPM_NAP;
    else               return LPM_NONE;
  endfunction

  // Core wake qualification: the decrementer counts only in nap.
  function automatic logic core_wake(input lpm_mode_e m, input wake_evt_t e);
    return e.ext_irq | e.smi | e.rst_evt | e.mcp | (e.dec & (m == LPM_NAP));
  endfunction

endpackage

// File: rtl/lpm_arm_gate.sv
module lpm_arm_gate
  import lpm_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      pwr_en_i,
  input  logic      core_off_i,
  input  logic      nap_bit_i,
  input  logic      sleep_bit_i,
  input  logic      accept_i,
  output logic      req_valid_o,
  output lpm_mode_e req_mode_o,
  output logic      seq_err_o
);

  logic pwr_en_q, core_off_q, nap_q, sleep_q, armed_q, seq_err_q;
  logic nap_rise, sleep_rise, any_rise, arm_evt, arm_ok, bad_req_evt;

  assign nap_rise   = nap_bit_i & ~nap_q;
  assign sleep_rise = sleep_bit_i & ~sleep_q;
  assign any_rise   = nap_rise | sleep_rise;
  // core-off must rise while power-enable was already set a cycle earlier
  assign arm_evt    = core_off_i & ~core_off_q & pwr_en_q & pwr_en_i;
  assign arm_ok     = armed_q & pwr_en_i & core_off_i;
  assign bad_req_evt = any_rise & accept_i & ~arm_ok;

  assign req_valid_o = any_rise & accept_i & arm_ok;
  assign req_mode_o  = pick_mode(nap_rise, sleep_rise);
  assign seq_err_o   = seq_err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwr_en_q   <= 1'b0;
      core_off_q <= 1'b0;
      nap_q      <= 1'b0;
      sleep_q    <= 1'b0;
      armed_q    <= 1'b0;
      seq_err_q  <= 1'b0;
    end else begin
      pwr_en_q   <= pwr_en_i;
      core_off_q <= core_off_i;
      nap_q      <= nap_bit_i;
      sleep_q    <= sleep_bit_i;
      if (!pwr_en_i || !core_off_i) armed_q <= 1'b0;
      else if (arm_evt)             armed_q <= 1'b1;
      if (bad_req_evt)              seq_err_q <= 1'b1;
    end
  end

  // R1: the error flag never clears outside reset
  a_r1_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    seq_err_o |=> seq_err_o);

  // R1: an accepted request implies both arming bits were high one cycle before
  a_r1_valid_after_arm: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid_o |-> ($past(pwr_en_i) && $past(core_off_i)));

endmodule

// File: rtl/lpm_wake_sel.sv
module lpm_wake_sel
  import lpm_pkg::*;
(
  input  lpm_mode_e mode_i,
  input  wake_evt_t evt_i,
  input  logic      alt_act_i,
  input  logic      bus_wake_en_i,
  output logic      core_hit_o,
  output logic      bus_hit_o
);

  assign core_hit_o = core_wake(mode_i, evt_i);
  assign bus_hit_o  = alt_act_i & bus_wake_en_i;

endmodule

// File: rtl/lpm_fsm.sv
module lpm_fsm
  import lpm_pkg::*;
#(
  parameter int WAKE_LAT = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid_i,
  input  lpm_mode_e  req_mode_i,
  input  logic       snoop_idle_i,
  input  logic       dram_off_i,
  input  logic       sr_ack_i,
  input  logic       core_hit_i,
  input  logic       bus_hit_i,
  output lpm_state_e state_o,
  output lpm_mode_e  mode_o,
  output logic       accept_o,
  output logic       core_gate_o,
  output logic       snoop_dis_o,
  output logic       sr_req_o,
  output logic       alt_block_o,
  output logic       wake_irq_o
);

  localparam int CNT_W = (WAKE_LAT > 1) ? $clog2(WAKE_LAT) : 1;
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(WAKE_LAT - 1);

  lpm_state_e       state_q;
  lpm_mode_e        mode_q;
  logic             sr_used_q, wake_irq_q;
  logic [CNT_W-1:0] cnt_q;

  // named internal events
  logic abort_evt, enter_evt, wake_evt, done_evt;
  assign abort_evt = (state_q == ST_WAIT_IDLE) & core_hit_i;
  assign enter_evt = (state_q == ST_WAIT_IDLE) & ~core_hit_i & snoop_idle_i;
  assign wake_evt  = (state_q == ST_LOW) & (core_hit_i | bus_hit_i);
  assign done_evt  = ((state_q == ST_FAST_WAKE) & (cnt_q == '0)) |
                     ((state_q == ST_SR_EXIT) & ~sr_ack_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_FULL;
      mode_q     <= LPM_NONE;
      sr_used_q  <= 1'b0;
      cnt_q      <= '0;
      wake_irq_q <= 1'b0;
    end else begin
      wake_irq_q <= (state_q == ST_LOW) & bus_hit_i;
      case (state_q)
        ST_FULL: if (req_valid_i) begin
          state_q <= ST_WAIT_IDLE;
          mode_q  <= req_mode_i;
        end
        ST_WAIT_IDLE: begin
          if (abort_evt) begin
            state_q <= ST_FULL;
            mode_q  <= LPM_NONE;
          end else if (enter_evt) begin
            sr_used_q <= dram_off_i;
            state_q   <= dram_off_i ? ST_SR_ENTER : ST_LOW;
          end
        end
        ST_SR_ENTER: if (sr_ack_i) state_q <= ST_LOW;
        ST_LOW: if (wake_evt) begin
          state_q <= sr_used_q ? ST_SR_EXIT : ST_FAST_WAKE;
          cnt_q   <= CNT_LOAD;
        end
        ST_SR_EXIT: if (done_evt) begin
          state_q   <= ST_FULL;
          mode_q    <= LPM_NONE;
          sr_used_q <= 1'b0;
        end
        ST_FAST_WAKE: begin
          if (done_evt) begin
            state_q <= ST_FULL;
            mode_q  <= LPM_NONE;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        default: begin
          state_q <= ST_FULL;
          mode_q  <= LPM_NONE;
        end
      endcase
    end
  end

  assign state_o     = state_q;
  assign mode_o      = mode_q;
  assign accept_o    = (state_q == ST_FULL);
  assign core_gate_o = (state_q == ST_SR_ENTER) | (state_q == ST_LOW) | (state_q == ST_SR_EXIT);
  assign snoop_dis_o = core_gate_o | (state_q == ST_FAST_WAKE);
  assign sr_req_o    = (state_q == ST_SR_ENTER) | ((state_q == ST_LOW) & sr_used_q);
  assign alt_block_o = sr_req_o | (state_q == ST_SR_EXIT);
  assign wake_irq_o  = wake_irq_q;

  // R3: snooping stops only after the snoop bus was seen idle
  a_r3_enter_after_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(snoop_dis_o) |-> $past(snoop_idle_i));

  // R4: a wake during the idle wait returns straight to full power
  a_r4_abort: assert property (@(posedge clk) disable iff (!rst_n)
    abort_evt |=> (state_q == ST_FULL) && !snoop_dis_o);

  // R5: self-refresh entry holds until the acknowledge arrives
  a_r5_sr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_SR_ENTER) && !sr_ack_i) |=> sr_req_o && (state_q == ST_SR_ENTER));

  // R6: entry without self-refresh leaves alternate masters unblocked
  a_r6_no_block: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(core_gate_o) && !sr_req_o) |-> !alt_block_o);

  // R9: the fast wake keeps snoop disabled while the counter runs
  a_r9_fast_run: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_FAST_WAKE) && (cnt_q != '0)) |=> snoop_dis_o);

  // R10: the block on alternate masters outlasts the self-refresh request
  a_r10_block_hold: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sr_req_o) |-> alt_block_o);

  // R11: the wake interrupt is a single-cycle pulse
  a_r11_irq_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    wake_irq_o |=> !wake_irq_o);

endmodule

// File: rtl/lpm_sequencer.sv
module lpm_sequencer
  import lpm_pkg::*;
#(
  parameter int WAKE_LAT = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pwr_en_i,
  input  logic       core_off_i,
  input  logic       nap_bit_i,
  input  logic       sleep_bit_i,
  input  logic       dram_off_i,
  input  logic       bus_wake_en_i,
  input  logic       snoop_idle_i,
  input  logic       ext_irq_i,
  input  logic       smi_i,
  input  logic       dec_irq_i,
  input  logic       rst_evt_i,
  input  logic       mcp_i,
  input  logic       alt_act_i,
  input  logic       sr_ack_i,
  output logic       core_gate_o,
  output logic       snoop_dis_o,
  output logic       sr_req_o,
  output logic       alt_block_o,
  output logic       wake_irq_o,
  output logic [1:0] lp_mode_o,
  output logic       seq_err_o
);

  lpm_state_e state_w;
  lpm_mode_e  mode_w, req_mode_w;
  logic       req_valid_w, accept_w, core_hit_w, bus_hit_w;
  wake_evt_t  evt_w;

  assign evt_w = '{ext_irq: ext_irq_i, smi: smi_i, dec: dec_irq_i,
                   rst_evt: rst_evt_i, mcp: mcp_i};

  lpm_arm_gate u_arm (
    .clk        (clk),
    .rst_n      (rst_n),
    .pwr_en_i   (pwr_en_i),
    .core_off_i (core_off_i),
    .nap_bit_i  (nap_bit_i),
    .sleep_bit_i(sleep_bit_i),
    .accept_i   (accept_w),
    .req_valid_o(req_valid_w),
    .req_mode_o (req_mode_w),
    .seq_err_o  (seq_err_o)
  );

  lpm_wake_sel u_wake (
    .mode_i       (mode_w),
    .evt_i        (evt_w),
    .alt_act_i    (alt_act_i),
    .bus_wake_en_i(bus_wake_en_i),
    .core_hit_o   (core_hit_w),
    .bus_hit_o    (bus_hit_w)
  );

  lpm_fsm #(.WAKE_LAT(WAKE_LAT)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid_i (req_valid_w),
    .req_mode_i  (req_mode_w),
    .snoop_idle_i(snoop_idle_i),
    .dram_off_i  (dram_off_i),
    .sr_ack_i    (sr_ack_i),
    .core_hit_i  (core_hit_w),
    .bus_hit_i   (bus_hit_w),
    .state_o     (state_w),
    .mode_o      (mode_w),
    .accept_o    (accept_w),
    .core_gate_o (core_gate_o),
    .snoop_dis_o (snoop_dis_o),
    .sr_req_o    (sr_req_o),
    .alt_block_o (alt_block_o),
    .wake_irq_o  (wake_irq_o)
  );

  assign lp_mode_o = mode_w;

  // R8: a lone decrementer interrupt keeps a sleeping core asleep
  a_r8_dec_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_w == ST_LOW) && (mode_w == LPM_SLEEP) && dec_irq_i && !ext_irq_i && !smi_i &&
     !rst_evt_i && !mcp_i && !(alt_act_i && bus_wake_en_i)) |=> (state_w == ST_LOW));

  // R7: any nap wake source leaves the low-power state
  a_r7_nap_wake: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_w == ST_LOW) && (mode_w == LPM_NAP) &&
     (ext_irq_i || smi_i || dec_irq_i || rst_evt_i || mcp_i)) |=> (state_w != ST_LOW));

  // R2: the reported mode is always one of the three legal codes
  a_r2_mode_code: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(lp_mode_o) <= 1);

endmodule

// File: tb/lpm_sequencer_bench.sv
`timescale 1ns/1ps
module lpm_sequencer_bench;

  localparam int LAT = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwr_en = 0, core_off = 0, nap_b = 0, sleep_b = 0, dram_off = 0, bus_en = 0;
  logic snoop_idle = 0, ext_irq = 0, smi = 0, dec_irq = 0, rst_evt = 0, mcp = 0, alt_act = 0;
  logic sr_ack = 0;
  logic core_gate, snoop_dis, sr_req, alt_block, wake_irq, seq_err;
  logic [1:0] lp_mode;

  int n_tests = 0, n_fail = 0, irq_cnt = 0, ack_dly = 0;
  bit auto_ack = 1'b1, done = 1'b0;

  always #4 clk = ~clk;

  lpm_sequencer #(.WAKE_LAT(LAT)) u_lpm_sequencer (
    .clk(clk), .rst_n(rst_n), .pwr_en_i(pwr_en), .core_off_i(core_off),
    .nap_bit_i(nap_b), .sleep_bit_i(sleep_b), .dram_off_i(dram_off),
    .bus_wake_en_i(bus_en), .snoop_idle_i(snoop_idle), .ext_irq_i(ext_irq),
    .smi_i(smi), .dec_irq_i(dec_irq), .rst_evt_i(rst_evt), .mcp_i(mcp),
    .alt_act_i(alt_act), .sr_ack_i(sr_ack), .core_gate_o(core_gate),
    .snoop_dis_o(snoop_dis), .sr_req_o(sr_req), .alt_block_o(alt_block),
    .wake_irq_o(wake_irq), .lp_mode_o(lp_mode), .seq_err_o(seq_err)
  );

  // DRAM controller model: copies the request into the acknowledge after a delay
  always @(negedge clk) begin
    if (wake_irq) irq_cnt++;
    if (auto_ack && rst_n) begin
      if (sr_ack != sr_req) begin
        if (ack_dly == 0) begin
          sr_ack  = sr_req;
          ack_dly = $urandom % 4;
        end else ack_dly--;
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int ref_mode(input bit nap, input bit sl);
    return sl ? 2 : (nap ? 1 : 0);
  endfunction

  // src: 0 ext, 1 smi, 2 dec, 3 reset event, 4 machine check, 5 bus activity
  function automatic bit ref_wakes(input int mode, input int src, input bit en);
    if (src == 2) return (mode == 1);
    if (src == 5) return en;
    return 1'b1;
  endfunction

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 0; pwr_en = 0; core_off = 0; nap_b = 0; sleep_b = 0; dram_off = 0;
    bus_en = 0; snoop_idle = 0; ext_irq = 0; smi = 0; dec_irq = 0; rst_evt = 0;
    mcp = 0; alt_act = 0; sr_ack = 0; auto_ack = 1;
    cyc(3);
    rst_n = 1;
    cyc(1);
  endtask

  task automatic arm();
    pwr_en = 1; cyc(1);
    core_off = 1; cyc(1);
  endtask

  task automatic disarm();
    nap_b = 0; sleep_b = 0; core_off = 0; pwr_en = 0; snoop_idle = 0;
    cyc(2);
  endtask

  task automatic set_src(input int src, input bit v);
    case (src)
      0: ext_irq = v;
      1: smi = v;
      2: dec_irq = v;
      3: rst_evt = v;
      4: mcp = v;
      default: alt_act = v;
    endcase
  endtask

  task automatic wait_full(input int lim, output bit ok);
    ok = 0;
    for (int i = 0; i < lim; i++) begin
      if (!snoop_dis && lp_mode == 2'b00) begin ok = 1; break; end
      @(negedge clk);
    end
  endtask

  task automatic wait_low(input int lim);
    for (int i = 0; i < lim; i++) begin
      if (core_gate && (!sr_req || sr_ack)) break;
      @(negedge clk);
    end
    cyc(1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    bit ok;
    int n;
    void'($urandom(32'h5eed_c0de));
    do_reset();
    // R12 reset state
    chk("R12 outputs after reset", {core_gate, snoop_dis, sr_req, alt_block, wake_irq, lp_mode, seq_err}, 0);

    // R1 request with nothing armed
    nap_b = 1; cyc(2);
    chk("R1 unarmed request ignored", lp_mode, 0);
    chk("R1 seq error set", seq_err, 1);
    nap_b = 0; cyc(3);
    chk("R1 seq error sticky", seq_err, 1);
    // R1 sticky error does not block a correct sequence
    arm(); snoop_idle = 1; sleep_b = 1; cyc(1);
    chk("R1 correct order accepted", lp_mode, 2);
    wait_low(20);
    ext_irq = 1; cyc(1); ext_irq = 0;
    wait_full(40, ok);
    chk("R1 returned to full", ok, 1);
    chk("R1 error still sticky", seq_err, 1);
    disarm();

    // R1 core-off before power-enable
    do_reset();
    core_off = 1; cyc(1); pwr_en = 1; cyc(1);
    nap_b = 1; cyc(2);
    chk("R1 reversed arming ignored", lp_mode, 0);
    chk("R1 reversed arming error", seq_err, 1);
    disarm();

    // R1 both arming bits in the same cycle
    do_reset();
    pwr_en = 1; core_off = 1; cyc(1);
    sleep_b = 1; cyc(2);
    chk("R1 simultaneous arming ignored", lp_mode, 0);
    chk("R1 simultaneous arming error", seq_err, 1);
    disarm();

    // R2 both requests together: sleep wins
    do_reset();
    arm(); nap_b = 1; sleep_b = 1; cyc(1);
    chk("R2 sleep priority", lp_mode, 2);
    chk("R3 waits for snoop idle", snoop_dis, 0);
    cyc(4);
    chk("R3 still waiting without idle", snoop_dis, 0);
    // R4 abort during the idle wait
    mcp = 1; cyc(1); mcp = 0;
    chk("R4 abort to full", lp_mode, 0);
    snoop_idle = 1; cyc(4);
    chk("R4 no entry after abort", snoop_dis, 0);
    chk("R1 no error for legal request", seq_err, 0);
    disarm();

    // R9 exact fast-wake latency
    do_reset();
    arm(); snoop_idle = 1; nap_b = 1; cyc(1);
    wait_low(20);
    chk("R6 no self-refresh request", sr_req, 0);
    chk("R6 alternates not blocked", alt_block, 0);
    chk("R3 core gated", core_gate, 1);
    dec_irq = 1;
    @(posedge clk);
    n = 0;
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      dec_irq = 0;
      if (!snoop_dis) break;
      n++;
    end
    chk("R9 fast wake latency", n, LAT);
    chk("R7 decrementer wakes nap", lp_mode, 0);
    disarm();

    // R8 decrementer ignored in sleep
    arm(); snoop_idle = 1; sleep_b = 1; cyc(1);
    wait_low(20);
    dec_irq = 1; cyc(6); dec_irq = 0;
    chk("R8 sleep ignores decrementer", core_gate, 1);
    chk("R8 mode stays sleep", lp_mode, 2);
    smi = 1; cyc(1); smi = 0;
    wait_full(40, ok);
    chk("R8 smi wakes sleep", ok, 1);
    disarm();

    // R5 / R10 manual self-refresh handshake
    auto_ack = 0; sr_ack = 0; dram_off = 1;
    arm(); snoop_idle = 1; sleep_b = 1; cyc(4);
    chk("R5 self-refresh requested", sr_req, 1);
    chk("R5 alternates blocked", alt_block, 1);
    chk("R5 holds without ack", core_gate, 1);
    sr_ack = 1; cyc(2);
    chk("R5 request held in low power", sr_req, 1);
    rst_evt = 1; cyc(1); rst_evt = 0;
    chk("R10 request dropped on wake", sr_req, 0);
    cyc(3);
    chk("R10 block held until ack low", alt_block, 1);
    chk("R10 snoop still off", snoop_dis, 1);
    sr_ack = 0; cyc(1);
    chk("R10 block released", alt_block, 0);
    chk("R10 full power after ack", {snoop_dis, lp_mode}, 0);
    auto_ack = 1; dram_off = 0;
    disarm();

    // R11 bus activity without enable in sleep
    arm(); snoop_idle = 1; sleep_b = 1; cyc(1);
    wait_low(20);
    n = irq_cnt;
    alt_act = 1; cyc(5); alt_act = 0;
    chk("R11 disabled bus wake ignored", core_gate, 1);
    chk("R11 no interrupt when disabled", irq_cnt - n, 0);
    ext_irq = 1; cyc(1); ext_irq = 0;
    wait_full(40, ok);
    disarm();

    // constrained random sweep
    for (int it = 0; it < 40; it++) begin
      int msel, src, mode, hold;
      bit en, nap, sl;
      msel = $urandom % 3; nap = (msel != 1); sl = (msel != 0);
      mode = ref_mode(nap, sl);
      dram_off = $urandom % 2; en = $urandom % 2; bus_en = en;
      src = $urandom % 6;
      arm();
      nap_b = nap; sleep_b = sl; cyc(1);
      chk("R2 random mode", lp_mode, mode);
      hold = $urandom % 4; cyc(hold);
      chk("R3 random idle wait", snoop_dis, 0);
      snoop_idle = 1;
      wait_low(30);
      chk("R5 random sr request", sr_req, dram_off);
      chk("R6 random block", alt_block, dram_off);
      n = irq_cnt;
      set_src(src, 1); cyc(2); set_src(src, 0);
      if (ref_wakes(mode, src, en)) begin
        wait_full(60, ok);
        chk("R7 random wake", ok, 1);
        chk("R11 random irq count", irq_cnt - n, (src == 5) ? 1 : 0);
      end else begin
        cyc(3);
        chk("R8 random ignored event", core_gate, 1);
        chk("R11 random no irq", irq_cnt - n, 0);
        ext_irq = 1; cyc(1); ext_irq = 0;
        wait_full(60, ok);
        chk("R7 random recovery", ok, 1);
      end
      disarm();
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule